// File: doc/BRIEF.md
# Address/Data Bus Tracking Buffer

This block makes an 8-bit general-purpose port follow the low byte of a multiplexed microcontroller address/data bus. Three select inputs, decoded elsewhere from bus-cycle terms, set the direction of the port on every clock:
- **Inbound select:** moves the value on the port pins onto the bus during read cycles.
- **Address select:** puts the latched address on the pins.
- **Write select:** puts the write data on the pins.

An internal latch captures the bus value while the address strobe is high. The latch holds that address after the bus moves on to its data phase.

The block supports two bus styles, chosen by one configuration input:
- **Strobe style:** separate active-low read and write strobes.
- **Enable style:** an active-high enable together with a read/not-write line.

The read and write qualifiers are decoded from the two bus-control inputs according to this style bit. A select whose qualifier is false is not honoured. All outputs are registered, in keeping with an FPGA target, so every result is due on the first rising clock edge after its inputs are presented.

Top module: `adbus_track_port`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `pad_oe`, `bus_oe`, `pad_out` and `bus_out` are all 0, and the address latch is cleared to 0.
- R2: At a clock edge where `addr_strobe` is 1, the latch loads `ad_in`; otherwise it keeps its value. With only `sel_addr_out` active, the next edge sets `pad_oe`=1, and `pad_out` equals the latch content after that edge.
- R3: In strobe style (`bus_style`=0), `sel_wr_out`=1 with `ctl_b`=0 (write strobe low) makes the next edge set `pad_oe`=1 and `pad_out`=`ad_in`.
- R4: In enable style (`bus_style`=1), `sel_wr_out`=1 with `ctl_a`=1 (enable high) and `ctl_b`=0 (write) makes the next edge set `pad_oe`=1 and `pad_out`=`ad_in`.
- R5: `sel_wr_out` is ignored when its write qualifier is false. The pins then show the latched address if `sel_addr_out` is 1, and are released otherwise.
- R6: In strobe style, `sel_in`=1 with `ctl_a`=0 (read strobe low) makes the next edge set `bus_oe`=1, `bus_out`=`pad_in` and `pad_oe`=0.
- R7: In enable style, `sel_in`=1 with `ctl_a`=1 and `ctl_b`=1 (read) makes the next edge set `bus_oe`=1, `bus_out`=`pad_in` and `pad_oe`=0.
- R8: A qualified inbound select takes priority over both outbound selects: `pad_oe` is 0 and `pad_oe` and `bus_oe` are never 1 together.
- R9: When the write and address selects are both honoured, the pins carry the write data (`ad_in`), not the latched address.
- R10: With no honoured select, the next edge sets both `pad_oe` and `bus_oe` to 0.
- R11: `sel_in` without its read qualifier leaves `bus_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_style | input | 1 | 0: separate read/write strobes, 1: enable plus read/not-write |
| ctl_a | input | 1 | Read strobe, active low (style 0), or enable, active high (style 1) |
| ctl_b | input | 1 | Write strobe, active low (style 0), or read/not-write (style 1) |
| addr_strobe | input | 1 | Address latch strobe, active high |
| ad_in | input | 8 | Value on the multiplexed low address/data bus |
| sel_in | input | 1 | Inbound select: pins to bus on read cycles |
| sel_addr_out | input | 1 | Address select: latched address to pins |
| sel_wr_out | input | 1 | Write select: write data to pins |
| pad_in | input | 8 | Value read from the port pins |
| pad_out | output | 8 | Value driven to the port pins |
| pad_oe | output | 1 | Pin output enable |
| bus_out | output | 8 | Value driven onto the bus |
| bus_oe | output | 1 | Bus drive enable |

## Verification
Every result of this block is due exactly one rising edge after its inputs: the direction enables, the pin value, the bus value and the latch update. The bench therefore drives each input pattern on a falling edge and samples the outputs on the next falling edge, half a period after the register has taken its value.

The bench sweeps every combination of the seven control inputs, with data values that change per step. A running model of the latch carries the address across steps, so the hold behaviour is checked whenever the strobe is low.

// File: rtl/adbus_track_pkg.sv
package adbus_track_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE    = 2'd0,
    DIR_TO_BUS  = 2'd1,
    DIR_WR_DATA = 2'd2,
    DIR_ADDR    = 2'd3
  } drive_e;

  localparam logic STYLE_STROBE = 1'b0;
  localparam logic STYLE_ENABLE = 1'b1;
endpackage

// File: rtl/trk_cycle_qual.sv
module trk_cycle_qual
  import adbus_track_pkg::*;
(
  input  logic bus_style,
  input  logic ctl_a,
  input  logic ctl_b,
  output logic rd_q,
  output logic wr_q
);
  always_comb begin
    if (bus_style == STYLE_ENABLE) begin
      rd_q = ctl_a & ctl_b;
      wr_q = ctl_a & ~ctl_b;
    end else begin
      rd_q = ~ctl_a;
      wr_q = ~ctl_b;
    end
  end
endmodule

// File: rtl/trk_addr_latch.sv
module trk_addr_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q_next,
  output logic [WIDTH-1:0] q
);
  assign q_next = strobe ? d : q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end

  // R2: capture while strobe high
  assert_latch_capture_R2: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (q == $past(d)));
  // R2: hold while strobe low
  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(q));
endmodule

// File: rtl/trk_dir_arbiter.sv
module trk_dir_arbiter
  import adbus_track_pkg::*;
(
  input  logic   sel_in,
  input  logic   sel_addr_out,
  input  logic   sel_wr_out,
  input  logic   rd_q,
  input  logic   wr_q,
  output drive_e mode
);
  always_comb begin
    if (sel_in && rd_q)          mode = DIR_TO_BUS;
    else if (sel_wr_out && wr_q) mode = DIR_WR_DATA;
    else if (sel_addr_out)       mode = DIR_ADDR;
    else                         mode = DIR_IDLE;
  end
endmodule

// File: rtl/adbus_track_port.sv
module adbus_track_port
  import adbus_track_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_style,
  input  logic             ctl_a,
  input  logic             ctl_b,
  input  logic             addr_strobe,
  input  logic [WIDTH-1:0] ad_in,
  input  logic             sel_in,
  input  logic             sel_addr_out,
  input  logic             sel_wr_out,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic             pad_oe,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_oe
);
  logic             rd_q, wr_q;
  logic [WIDTH-1:0] latch_nxt, latch_q;
  logic [WIDTH-1:0] pad_nxt, bus_nxt;
  drive_e           mode;

  trk_cycle_qual u_qual (
    .bus_style (bus_style),
    .ctl_a     (ctl_a),
    .ctl_b     (ctl_b),
    .rd_q      (rd_q),
    .wr_q      (wr_q)
  );

  trk_addr_latch #(.WIDTH(WIDTH)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .strobe (addr_strobe),
    .d      (ad_in),
    .q_next (latch_nxt),
    .q      (latch_q)
  );

  trk_dir_arbiter u_arb (
    .sel_in       (sel_in),
    .sel_addr_out (sel_addr_out),
    .sel_wr_out   (sel_wr_out),
    .rd_q         (rd_q),
    .wr_q         (wr_q),
    .mode         (mode)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_comb begin
      unique case (mode)
        DIR_WR_DATA: pad_nxt[b] = ad_in[b];
        DIR_ADDR:    pad_nxt[b] = latch_nxt[b];
        default:     pad_nxt[b] = pad_out[b];
      endcase
      bus_nxt[b] = (mode == DIR_TO_BUS) ? pad_in[b] : bus_out[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= 1'b0;
      bus_out <= '0;
      bus_oe  <= 1'b0;
    end else begin
      pad_out <= pad_nxt;
      bus_out <= bus_nxt;
      pad_oe  <= (mode == DIR_WR_DATA) || (mode == DIR_ADDR);
      bus_oe  <= (mode == DIR_TO_BUS);
    end
  end

  // R8: never both drivers on
  assert_no_contention_R8: assert property (@(posedge clk) disable iff (rst)
    !(pad_oe && bus_oe));
  // R6: strobe-style read
  assert_read_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    (sel_in && !bus_style && !ctl_a) |=> (bus_oe && !pad_oe && bus_out == $past(pad_in)));
  // R7: enable-style read
  assert_read_enable_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_in && bus_style && ctl_a && ctl_b) |=> (bus_oe && !pad_oe && bus_out == $past(pad_in)));
  // R3: strobe-style write data
  assert_write_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    (!sel_in && sel_wr_out && !bus_style && !ctl_b) |=> (pad_oe && pad_out == $past(ad_in)));
  // R4: enable-style write data
  assert_write_enable_R4: assert property (@(posedge clk) disable iff (rst)
    (!sel_in && sel_wr_out && bus_style && ctl_a && !ctl_b) |=> (pad_oe && pad_out == $past(ad_in)));
  // R10: idle releases both sides
  assert_idle_release_R10: assert property (@(posedge clk) disable iff (rst)
    (!sel_in && !sel_addr_out && !sel_wr_out) |=> (!pad_oe && !bus_oe));
  // R11: unqualified inbound select never drives the bus
  assert_in_unqualified_R11: assert property (@(posedge clk) disable iff (rst)
    (!bus_style && ctl_a) |=> !bus_oe);
endmodule

// File: tb/adbus_track_port_tb.sv
module adbus_track_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_style = 1'b0, ctl_a = 1'b1, ctl_b = 1'b1, addr_strobe = 1'b0;
  logic [7:0] ad_in = '0, pad_in = '0;
  logic       sel_in = 1'b0, sel_addr_out = 1'b0, sel_wr_out = 1'b0;
  logic [7:0] pad_out, bus_out;
  logic       pad_oe, bus_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adbus_track_port #(.WIDTH(8)) dut_i (
    .clk(clk), .rst(rst), .bus_style(bus_style), .ctl_a(ctl_a), .ctl_b(ctl_b),
    .addr_strobe(addr_strobe), .ad_in(ad_in), .sel_in(sel_in),
    .sel_addr_out(sel_addr_out), .sel_wr_out(sel_wr_out), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    logic [7:0] latch_m;
    latch_m = '0;
    repeat (3) @(negedge clk);
    // R1: during reset
    check("R1", "pad_oe", int'(pad_oe), 0);
    check("R1", "bus_oe", int'(bus_oe), 0);
    check("R1", "pad_out", int'(pad_out), 0);
    check("R1", "bus_out", int'(bus_out), 0);
    rst = 1'b0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 128; i++) begin
        logic rq, wq, in_act, wr_act, e_poe, e_boe;
        logic [7:0] ad_v, pd_v, nxt_latch;
        string tag;
        ad_v = 8'((i + pass * 128) * 37 + 5);
        pd_v = 8'((i + pass * 128) * 91 + 3);
        {bus_style, ctl_a, ctl_b, addr_strobe, sel_in, sel_addr_out, sel_wr_out} = 7'(pass == 0 ? i : 127 - i);
        ad_in = ad_v; pad_in = pd_v;
        rq = bus_style ? (ctl_a & ctl_b) : ~ctl_a;
        wq = bus_style ? (ctl_a & ~ctl_b) : ~ctl_b;
        in_act = sel_in & rq;
        wr_act = sel_wr_out & wq;
        nxt_latch = addr_strobe ? ad_v : latch_m;
        e_poe = !in_act && (wr_act || sel_addr_out);
        e_boe = in_act;
        if (in_act)             tag = (sel_addr_out || sel_wr_out) ? "R8" : (bus_style ? "R7" : "R6");
        else if (wr_act)        tag = sel_addr_out ? "R9" : (bus_style ? "R4" : "R3");
        else if (sel_addr_out)  tag = sel_wr_out ? "R5" : "R2";
        else if (sel_in)        tag = "R11";
        else                    tag = sel_wr_out ? "R5" : "R10";
        @(negedge clk);
        check(tag, "pad_oe", int'(pad_oe), int'(e_poe));
        check(tag, "bus_oe", int'(bus_oe), int'(e_boe));
        if (e_boe) check(tag, "bus_out", int'(bus_out), int'(pd_v));
        if (e_poe) check(tag, "pad_out", int'(pad_out), int'(wr_act ? ad_v : nxt_latch));
        latch_m = nxt_latch;
      end
    end
    // R1: reset again clears everything on the first edge
    sel_addr_out = 1'b1; addr_strobe = 1'b1; ad_in = 8'hA5; sel_in = 1'b0; sel_wr_out = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R1", "pad_oe after reset", int'(pad_oe), 0);
    check("R1", "pad_out after reset", int'(pad_out), 0);
    rst = 1'b0; addr_strobe = 1'b0;
    @(negedge clk);
    // R2: latch was cleared by reset, strobe low keeps 0
    check("R2", "latch after reset", int'(pad_out), 0);
    check("R2", "pad_oe addr", int'(pad_oe), 1);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule